// File: doc/BRIEF.md
# Display Control Port Register Block

This block sits on the byte-wide I/O bus of a display controller. It decodes writes to a group of eight even offsets, selected by a chip select and a 4-bit offset. It holds two kinds of state.

The first is a bank of six timing registers, five bits wide each. A flag next to them asks the display side to redraw the whole screen. The flag is raised only when a write really changes a stored value. It stays up until the display side acknowledges it.

The second is a plane-colour unit. It has a mode register, four tile registers that all load through one data offset, and a 2-bit load pointer that wraps. The mode byte can be read back. The block drives three things to a downstream video-memory operator: the decoded plane-operation select, a coupling field and the tile contents. The parameter `UNIT_REV` sets the revision of the plane-colour unit. Revision 0 means the unit is absent. A synchronous BIOS-level reset loads one of two timing presets, chosen by a configuration strap.

Top module: `gfx_port_regs`

## Requirements
- R1: A cycle with `bios_rst` high sets the following state at that clock edge. The redraw flag goes to 1. Mode, plane select, coupling field, all tiles and the tile pointer go to 0. The timing slots take a preset chosen by `cfg_strap`. With the strap at 0, slot 1 = 0x0F and slot 2 = 0x10. With the strap at 1, slot 1 = 0x07 and slot 2 = 0x08. Slots 0, 3, 4 and 5 are 0 in both cases. `bios_rst` wins over a write in the same cycle.
- R2: A write to even offset 2k, with k from 0 to 5, stores `wdata[4:0]` in timing slot k. The upper three data bits are dropped. Slot k appears on `crtc_o[5k+4:5k]`. The other slots keep their values.
- R3: A timing write whose masked value equals the stored value changes no slot and does not raise the redraw flag.
- R4: A timing write whose masked value differs from the stored value sets `redraw_o` at the next clock edge.
- R5: A `redraw_ack` pulse clears `redraw_o` at the next clock edge. If a value-changing timing write arrives in the same cycle as the pulse, the flag stays at 1.
- R6: When `UNIT_REV` is not 0, a write to offset 0xC does three things: it stores the whole byte as the mode, it sets `plane_op_o` to `wdata[7:6]`, and it sets the tile pointer to 0.
- R7: When `UNIT_REV` is 2 or more, a mode write sets `couple_o` to `{wdata[7:6], 2'b00}`. On lower revisions `couple_o` never changes.
- R8: A write to offset 0xE loads the tile at the pointer and then advances the pointer modulo 4. Tile i appears on `tiles_o[8i+7:8i]`. The fifth write in a row goes back to tile 0.
- R9: `rd_data` is combinational. It shows the stored mode byte while `cs` is high and `ofs` is 0xC. In every other case it is 0.
- R10: When `UNIT_REV` is 0, mode writes are ignored: the mode, the plane select, the coupling field and the pointer all stay unchanged. Tile writes still act as in R8.
- R11: A write is ignored in three cases: the offset is odd, `cs` is low, or `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bios_rst | input | 1 | Synchronous BIOS-level reset, active high |
| cfg_strap | input | 1 | Selects the timing preset |
| cs | input | 1 | Chip select for the port group |
| wr_en | input | 1 | Single-cycle write strobe |
| ofs | input | 4 | Port offset within the group |
| wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Read-back data (mode byte at offset 0xC) |
| redraw_ack | input | 1 | Display side acknowledges the redraw request |
| redraw_o | output | 1 | Full-screen redraw request |
| crtc_o | output | 30 | Six 5-bit timing slots, slot 0 in the low bits |
| plane_op_o | output | 2 | Plane-operation select |
| couple_o | output | 4 | Coupling field |
| tiles_o | output | 32 | Four tile bytes, tile 0 in the low byte |

## Verification
Two events can fall in the same cycle: a value-changing timing write that raises the redraw flag, and the acknowledge that lowers it. The bench provokes this by asserting `redraw_ack` together with a write of a new value, and expects the flag to stay at 1. It also pairs the acknowledge with a write of an unchanged value, and expects the flag to drop to 0. Every byte value is written twice to every slot, so each write is judged both as a change and as a repeat.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int OFS_W = 4;
    localparam int IDX_W = OFS_W - 1;
    localparam logic [IDX_W-1:0] MODE_IDX = 3'd6;
    localparam logic [IDX_W-1:0] TILE_IDX = 3'd7;
    localparam logic [4:0] PRE_BLANK_S0 = 5'h0F;
    localparam logic [4:0] PRE_BLANK_S1 = 5'h07;
    localparam logic [4:0] PRE_CELL_S0  = 5'h10;
    localparam logic [4:0] PRE_CELL_S1  = 5'h08;

    typedef struct packed {
        logic             crtc_we;
        logic             mode_we;
        logic             tile_we;
        logic [IDX_W-1:0] idx;
    } gpr_dec_t;
endpackage

// File: rtl/gpr_decode.sv
module gpr_decode
    import gpr_pkg::*;
#(
    parameter int CRTC_SLOTS = 6
) (
    input  logic             cs,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] ofs,
    output gpr_dec_t         dec
);
    logic strobe;

    always_comb begin
        strobe      = cs && wr_en && !ofs[0];
        dec.idx     = ofs[OFS_W-1:1];
        dec.mode_we = strobe && (dec.idx == MODE_IDX);
        dec.tile_we = strobe && (dec.idx == TILE_IDX);
        dec.crtc_we = strobe && (int'(dec.idx) < CRTC_SLOTS);
    end

    // R11
    always_comb begin
        one_target_chk: assert ($onehot0({dec.crtc_we, dec.mode_we, dec.tile_we}));
    end
endmodule

// File: rtl/gpr_crtc_bank.sv
module gpr_crtc_bank
    import gpr_pkg::*;
#(
    parameter int SLOTS  = 6,
    parameter int W      = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    output logic [SLOTS*W-1:0] regs_o,
    output logic              redraw_o
);
    typedef struct packed {
        logic [SLOTS-1:0][W-1:0] regs;
        logic                    redraw;
    } st_t;

    st_t        st_d, st_q;
    logic [W-1:0] val;
    logic [W-1:0] cur;
    logic         differs;

    function automatic logic [SLOTS-1:0][W-1:0] preset(input logic s);
        logic [SLOTS-1:0][W-1:0] p;
        p    = '0;
        p[1] = s ? W'(PRE_BLANK_S1) : W'(PRE_BLANK_S0);
        p[2] = s ? W'(PRE_CELL_S1)  : W'(PRE_CELL_S0);
        return p;
    endfunction

    always_comb begin
        val     = wdata[W-1:0];
        cur     = st_q.regs[idx];
        differs = we && (cur != val);
        st_d    = st_q;
        if (ack) st_d.redraw = 1'b0;
        if (differs) begin
            st_d.regs[idx] = val;
            st_d.redraw    = 1'b1;
        end
        if (rst) begin
            st_d.regs   = preset(strap);
            st_d.redraw = 1'b1;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign regs_o   = st_q.regs;
    assign redraw_o = st_q.redraw;

    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= armed_q | rst;

    // R1
    crtc_reset_chk: assert property (@(posedge clk) disable iff (!armed_q)
        rst |=> redraw_o);
    // R3
    same_value_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (!rst && we && !ack && !redraw_o && cur == val) |=> (!redraw_o && $stable(regs_o)));
    // R4
    change_raise_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (!rst && we && cur != val) |=> redraw_o);
    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (!rst && ack && !we) |=> !redraw_o);
endmodule

// File: rtl/gpr_charger.sv
module gpr_charger
    import gpr_pkg::*;
#(
    parameter int TILES    = 4,
    parameter int DATA_W   = 8,
    parameter int UNIT_REV = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode_we,
    input  logic                    tile_we,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       mode_o,
    output logic [1:0]              op_o,
    output logic [3:0]              couple_o,
    output logic [TILES*DATA_W-1:0] tiles_o
);
    localparam int PTR_W      = $clog2(TILES);
    localparam bit HAS_UNIT   = (UNIT_REV != 0);
    localparam bit HAS_COUPLE = (UNIT_REV >= 2);

    typedef struct packed {
        logic [DATA_W-1:0]             mode;
        logic [PTR_W-1:0]              ptr;
        logic [1:0]                    op;
        logic [1:0]                    couple;
        logic [TILES-1:0][DATA_W-1:0]  tiles;
    } st_t;

    st_t st_d, st_q;
    logic [PTR_W-1:0] ptr_next;

    always_comb begin
        ptr_next = (st_q.ptr == PTR_W'(TILES - 1)) ? '0 : st_q.ptr + 1'b1;
        st_d     = st_q;
        if (tile_we) begin
            st_d.tiles[st_q.ptr] = wdata;
            st_d.ptr             = ptr_next;
        end
        if (mode_we && HAS_UNIT) begin
            st_d.mode = wdata;
            st_d.ptr  = '0;
            st_d.op   = wdata[DATA_W-1:DATA_W-2];
            if (HAS_COUPLE) st_d.couple = wdata[DATA_W-1:DATA_W-2];
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign mode_o   = st_q.mode;
    assign op_o     = st_q.op;
    assign couple_o = {st_q.couple, 2'b00};
    assign tiles_o  = st_q.tiles;

    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= armed_q | rst;

    // R1
    unit_reset_chk: assert property (@(posedge clk) disable iff (!armed_q)
        rst |=> (mode_o == '0 && st_q.ptr == '0 && tiles_o == '0));
    // R8
    tile_step_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (!rst && tile_we && !mode_we) |=> (st_q.ptr == $past(ptr_next)));

    generate
        if (HAS_UNIT) begin : g_unit
            // R6
            mode_load_chk: assert property (@(posedge clk) disable iff (!armed_q)
                (!rst && mode_we) |=> (st_q.ptr == '0 && mode_o == $past(wdata)));
        end else begin : g_absent
            // R10
            mode_ignore_chk: assert property (@(posedge clk) disable iff (!armed_q)
                (!rst && mode_we) |=> ($stable(mode_o) && $stable(op_o)));
        end
        if (!HAS_COUPLE) begin : g_nocouple
            // R7
            couple_hold_chk: assert property (@(posedge clk) disable iff (!armed_q)
                !rst |=> $stable(couple_o));
        end
    endgenerate
endmodule

// File: rtl/gfx_port_regs.sv
module gfx_port_regs
    import gpr_pkg::*;
#(
    parameter int CRTC_SLOTS = 6,
    parameter int CRTC_W     = 5,
    parameter int DATA_W     = 8,
    parameter int TILES      = 4,
    parameter int UNIT_REV   = 2
) (
    input  logic                         clk,
    input  logic                         bios_rst,
    input  logic                         cfg_strap,
    input  logic                         cs,
    input  logic                         wr_en,
    input  logic [OFS_W-1:0]             ofs,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rd_data,
    input  logic                         redraw_ack,
    output logic                         redraw_o,
    output logic [CRTC_SLOTS*CRTC_W-1:0] crtc_o,
    output logic [1:0]                   plane_op_o,
    output logic [3:0]                   couple_o,
    output logic [TILES*DATA_W-1:0]      tiles_o
);
    localparam logic [OFS_W-1:0] MODE_OFS = {MODE_IDX, 1'b0};

    gpr_dec_t          dec;
    logic [DATA_W-1:0] mode_q;

    gpr_decode #(.CRTC_SLOTS(CRTC_SLOTS)) i_decode (
        .cs    (cs),
        .wr_en (wr_en),
        .ofs   (ofs),
        .dec   (dec)
    );

    gpr_crtc_bank #(.SLOTS(CRTC_SLOTS), .W(CRTC_W), .DATA_W(DATA_W)) i_crtc (
        .clk      (clk),
        .rst      (bios_rst),
        .strap    (cfg_strap),
        .we       (dec.crtc_we),
        .idx      (dec.idx),
        .wdata    (wdata),
        .ack      (redraw_ack),
        .regs_o   (crtc_o),
        .redraw_o (redraw_o)
    );

    gpr_charger #(.TILES(TILES), .DATA_W(DATA_W), .UNIT_REV(UNIT_REV)) i_charger (
        .clk      (clk),
        .rst      (bios_rst),
        .mode_we  (dec.mode_we),
        .tile_we  (dec.tile_we),
        .wdata    (wdata),
        .mode_o   (mode_q),
        .op_o     (plane_op_o),
        .couple_o (couple_o),
        .tiles_o  (tiles_o)
    );

    assign rd_data = (cs && ofs == MODE_OFS) ? mode_q : '0;
endmodule

// File: tb/test_gfx_port_regs.sv
module test_gfx_port_regs;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       bios_rst = 1'b0, cfg_strap = 1'b0, cs = 1'b0, wr_en = 1'b0, redraw_ack = 1'b0;
    logic [3:0] ofs = '0;
    logic [7:0] wdata = '0;

    logic [7:0]  rd2, rd1, rd0;
    logic        rdw2, rdw1, rdw0;
    logic [29:0] cr2, cr1, cr0;
    logic [1:0]  op2, op1, op0;
    logic [3:0]  cp2, cp1, cp0;
    logic [31:0] tl2, tl1, tl0;

    gfx_port_regs #(.UNIT_REV(2)) i_gfx_port_regs (
        .clk(clk), .bios_rst(bios_rst), .cfg_strap(cfg_strap), .cs(cs), .wr_en(wr_en),
        .ofs(ofs), .wdata(wdata), .rd_data(rd2), .redraw_ack(redraw_ack), .redraw_o(rdw2),
        .crtc_o(cr2), .plane_op_o(op2), .couple_o(cp2), .tiles_o(tl2));
    gfx_port_regs #(.UNIT_REV(1)) i_rev1 (
        .clk(clk), .bios_rst(bios_rst), .cfg_strap(cfg_strap), .cs(cs), .wr_en(wr_en),
        .ofs(ofs), .wdata(wdata), .rd_data(rd1), .redraw_ack(redraw_ack), .redraw_o(rdw1),
        .crtc_o(cr1), .plane_op_o(op1), .couple_o(cp1), .tiles_o(tl1));
    gfx_port_regs #(.UNIT_REV(0)) i_rev0 (
        .clk(clk), .bios_rst(bios_rst), .cfg_strap(cfg_strap), .cs(cs), .wr_en(wr_en),
        .ofs(ofs), .wdata(wdata), .rd_data(rd0), .redraw_ack(redraw_ack), .redraw_o(rdw0),
        .crtc_o(cr0), .plane_op_o(op0), .couple_o(cp0), .tiles_o(tl0));

    int total = 0, bad = 0;
    int exp_crtc[6];
    int exp_tile[4], exp_tile0[4];
    int exp_ptr, exp_ptr0, exp_mode, exp_redraw;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [29:0] pack_crtc();
        logic [29:0] p = '0;
        for (int k = 0; k < 6; k++) p[5*k +: 5] = exp_crtc[k][4:0];
        return p;
    endfunction

    function automatic logic [31:0] pack_tiles(input bit rev0);
        logic [31:0] p = '0;
        for (int i = 0; i < 4; i++) p[8*i +: 8] = rev0 ? exp_tile0[i][7:0] : exp_tile[i][7:0];
        return p;
    endfunction

    task automatic wr(input logic [3:0] o, input logic [7:0] d, input logic a, input logic c);
        @(negedge clk);
        cs = c; wr_en = 1'b1; ofs = o; wdata = d; redraw_ack = a;
        @(negedge clk);
        cs = 1'b0; wr_en = 1'b0; redraw_ack = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        redraw_ack = 1'b1;
        @(negedge clk);
        redraw_ack = 1'b0;
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        cfg_strap = s; bios_rst = 1'b1;
        @(negedge clk);
        bios_rst = 1'b0;
        for (int k = 0; k < 6; k++) exp_crtc[k] = 0;
        exp_crtc[1] = s ? 7 : 15;
        exp_crtc[2] = s ? 8 : 16;
        for (int i = 0; i < 4; i++) begin exp_tile[i] = 0; exp_tile0[i] = 0; end
        exp_ptr = 0; exp_ptr0 = 0; exp_mode = 0; exp_redraw = 1;
    endtask

    task automatic chk_reset(input string tag);
        chk({tag, " R1 crtc"}, cr2, pack_crtc());
        chk({tag, " R1 redraw"}, rdw2, 1);
        chk({tag, " R1 tiles"}, tl2, 0);
        chk({tag, " R1 op"}, op2, 0);
        chk({tag, " R1 couple"}, cp2, 0);
        @(negedge clk); cs = 1'b1; ofs = 4'hC; #1;
        chk({tag, " R1 mode"}, rd2, 0);
        cs = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        chk_reset("strap0");
        ack_pulse(); exp_redraw = 0;
        chk("R5 ack clears", rdw2, 0);

        // R2 R3 R4: every byte twice into every slot
        for (int k = 0; k < 6; k++) begin
            for (int d = 0; d < 256; d++) begin
                for (int rep = 0; rep < 2; rep++) begin
                    bit changed;
                    changed = ((d & 31) != exp_crtc[k]);
                    wr(4'(2 * k), 8'(d), 1'b0, 1'b1);
                    if (changed) begin exp_crtc[k] = d & 31; exp_redraw = 1; end
                    chk("R2 slot store", cr2, pack_crtc());
                    chk(changed ? "R4 redraw raised" : "R3 no redraw", rdw2, exp_redraw);
                    if (exp_redraw == 1) begin
                        ack_pulse(); exp_redraw = 0;
                        chk("R5 ack clears", rdw2, 0);
                    end
                end
            end
        end

        // R5 same-cycle raise and acknowledge
        wr(4'h4, 8'h1A, 1'b1, 1'b1); exp_crtc[2] = 5'h1A;
        chk("R5 set wins over ack", rdw2, 1);
        wr(4'h4, 8'h1A, 1'b1, 1'b1);
        chk("R5 ack with same-value write", rdw2, 0);
        chk("R3 slot unchanged", cr2, pack_crtc());

        // R6 R7 R8 R9 R10: mode sweep with tile bursts
        for (int m = 0; m < 256; m++) begin
            wr(4'hC, 8'(m), 1'b0, 1'b1);
            exp_mode = m; exp_ptr = 0;
            @(negedge clk); cs = 1'b1; ofs = 4'hC; #1;
            chk("R9 mode read", rd2, m);
            chk("R10 absent mode read", rd0, 0);
            cs = 1'b0;
            chk("R6 plane op", op2, m >> 6);
            chk("R7 couple rev2", cp2, (m >> 4) & 12);
            chk("R7 couple rev1", cp1, 0);
            chk("R10 absent op", op0, 0);
            for (int t = 0; t < 1 + (m % 5); t++) begin
                int d;
                d = (m * 7 + t * 29) & 255;
                wr(4'hE, 8'(d), 1'b0, 1'b1);
                exp_tile[exp_ptr] = d; exp_ptr = (exp_ptr + 1) % 4;
                exp_tile0[exp_ptr0] = d; exp_ptr0 = (exp_ptr0 + 1) % 4;
                chk("R8 tile load", tl2, pack_tiles(0));
                chk("R10 absent tiles", tl0, pack_tiles(1));
            end
        end

        // R11 ignored writes
        wr(4'h1, 8'hFF, 1'b0, 1'b1);
        wr(4'hD, 8'h55, 1'b0, 1'b1);
        wr(4'hF, 8'h77, 1'b0, 1'b1);
        wr(4'h0, 8'h1F, 1'b0, 1'b0);
        wr(4'hC, 8'h00, 1'b0, 1'b0);
        @(negedge clk); ofs = 4'hC; wdata = 8'h11; cs = 1'b1; #1;
        chk("R11 odd or deselected crtc", cr2, pack_crtc());
        chk("R11 tiles kept", tl2, pack_tiles(0));
        chk("R11 mode kept", rd2, exp_mode);
        chk("R11 no redraw", rdw2, 0);
        ofs = 4'h8; #1;
        chk("R9 other offset reads zero", rd2, 0);
        cs = 1'b0; #1;
        ofs = 4'hC; #1;
        chk("R9 deselected read zero", rd2, 0);

        // R1 with write in the same cycle, strap set
        @(negedge clk);
        cfg_strap = 1'b1; bios_rst = 1'b1; cs = 1'b1; wr_en = 1'b1; ofs = 4'h2; wdata = 8'h03;
        @(negedge clk);
        bios_rst = 1'b0; cs = 1'b0; wr_en = 1'b0;
        do_reset(1'b1);
        chk_reset("strap1");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule